// File: doc/BRIEF.md
# LPI Pending-Bit Update Engine

This block applies set and clear requests for a single message-signalled interrupt (an LPI) to a pending table kept in system memory. It also keeps the record of the highest-priority pending LPI current. Each request carries an interrupt ID and a target level. The engine first screens the request against the current configuration. It then reads the pending-table byte that holds the interrupt's bit. If the bit already has the requested level, the engine writes nothing and changes nothing else. Otherwise it writes the byte back with only that bit changed.

After a set that changed the bit, the engine reads the interrupt's own configuration byte. It compares the resulting priority once against the stored best, with no table walk. After a clear of the interrupt that is currently recorded as best, it asks an external scanner for a full rescan and loads the scanner's answer. A clear of any other ID leaves the best record alone. Each request that passes the screen ends with a one-cycle pulse that tells the CPU interface to re-evaluate its output.

The controller is a single state machine with these states:
- `ST_IDLE`: ready for a request.
- `ST_PEND_RD`: reads the pending byte.
- `ST_PEND_WR`: writes the pending byte back.
- `ST_CFG_RD`: reads the configuration byte.
- `ST_RESCAN`: waits on the scanner.
- `ST_NOTIFY`: issues the update pulse.

Its transitions are:
- **accept**: `ST_IDLE` to `ST_PEND_RD`.
- **drop**: `ST_IDLE` to `ST_IDLE`.
- **no-change**: `ST_PEND_RD` to `ST_NOTIFY`.
- **modify**: `ST_PEND_RD` to `ST_PEND_WR`.
- **set-done-write**: `ST_PEND_WR` to `ST_CFG_RD`.
- **clear-best**: `ST_PEND_WR` to `ST_RESCAN`.
- **clear-other**: `ST_PEND_WR` to `ST_NOTIFY`.
- **cfg-done**: `ST_CFG_RD` to `ST_NOTIFY`.
- **scan-done**: `ST_RESCAN` to `ST_NOTIFY`.
- **notify**: `ST_NOTIFY` to `ST_IDLE`.

Top module: `lpi_pend_upd`

## Requirements
- R1: A request accepted while `lpi_en` is low, or while `prop_base` or `pend_base` is zero, is dropped. A request is also dropped when its ID is below `LPI_FIRST` (8192), or when its ID is above 2^(min(`idbits`,`MAX_IDBITS`)+1) − 1. A dropped request makes no memory access, gives no `cpu_update` pulse and leaves `req_ready` high. The ID 2^(idbits+1) − 1 itself is accepted.
- R2: The pending bit for an ID is bit `ID[2:0]` of the byte at address `pend_base + (ID >> 3)`.
- R3: The pending byte is read first. If its bit already equals `req_level`, no write follows and the best record is unchanged.
- R4: Otherwise the same byte is written back with only that bit changed, to the value of `req_level`.
- R5: After a set that wrote, the configuration byte at `prop_base + (ID − 8192)` is read. Bit 0 of that byte enables the interrupt. Bits 7:2 hold the priority field `P = byte & 0xFC`. The effective priority is `P` when `prio_direct` is 1, and `(P >> 1) | 0x80` when `prio_direct` is 0. A disabled interrupt never changes the best record.
- R6: An enabled candidate replaces the best when its priority is lower than `best_prio`. It also replaces the best when its priority is equal to `best_prio` and its ID is less than or equal to `best_id`. The set path never requests a rescan.
- R7: A clear that wrote raises `scan_req` only when the ID equals `best_id`. `scan_req` stays high until `scan_done`, when `scan_id`/`scan_prio` become the best. A clear of any other ID leaves the best unchanged.
- R8: Every request that is not dropped ends with exactly one single-cycle `cpu_update` pulse, and `req_ready` returns high in the next cycle.
- R9: Requests are handled one at a time: `req_ready` is low from the cycle after acceptance until the pulse. A memory request holds `mem_req`, `mem_we` and `mem_addr` stable until `mem_ack`, which may come one or more cycles later.
- R10: After reset, `req_ready` is 1, `mem_req`, `scan_req` and `cpu_update` are 0, `best_prio` is 0xFF and `best_id` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lpi_en | input | 1 | LPI handling enabled |
| prio_direct | input | 1 | 1: use priority field as is; 0: remap into upper half |
| prop_base | input | ADDR_W | Configuration table base address |
| pend_base | input | ADDR_W | Pending table base address |
| idbits | input | IDB_W | Interrupt ID width field (ID space is 2^(idbits+1)) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle and able to accept |
| req_id | input | ID_W | Interrupt ID of the request |
| req_level | input | 1 | 1 = set pending, 0 = clear pending |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 8 | Read data |
| best_id | output | ID_W | ID of highest-priority pending LPI |
| best_prio | output | 8 | Priority of that LPI (0xFF = none) |
| scan_req | output | 1 | Full rescan request to scanner |
| scan_done | input | 1 | Scanner finished; result valid |
| scan_id | input | ID_W | Scanner result ID |
| scan_prio | input | 8 | Scanner result priority |
| cpu_update | output | 1 | One-cycle pulse: CPU interface should re-evaluate |

## Verification
The main function is driven with a sequence of set and clear requests against a table preloaded with enabled and disabled entries. Some IDs share one pending byte, to check that the byte-merge preserves the neighbouring bits. Repeating a set or a clear on the same ID distinguishes the skipped write from the modifying write. Equal-priority candidates with higher and lower IDs separate the tie-break from the strict-lower rule. Clears of the best ID and of a non-best ID separate the rescan path from the untouched path. The memory latency is varied between one and three cycles, the priority remap is tried in both modes, and each drop condition is applied alone, next to the accepted ID-range boundary.

// File: rtl/lpi_pend_pkg.sv
package lpi_pend_pkg;

    localparam int unsigned PRIO_W     = 8;
    localparam logic [7:0]  PRIO_IDLE  = 8'hFF;
    localparam logic [7:0]  PRIO_FIELD = 8'hFC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND_RD,
        ST_PEND_WR,
        ST_CFG_RD,
        ST_RESCAN,
        ST_NOTIFY
    } hdl_state_e;

    // Effective priority of a configuration byte (R5).
    function automatic logic [7:0] remap_prio(input logic [7:0] cfg, input logic direct);
        logic [7:0] raw;
        raw = cfg & PRIO_FIELD;
        return direct ? raw : ({1'b0, raw[7:1]} | 8'h80);
    endfunction

endpackage

// File: rtl/lpi_req_filter.sv
module lpi_req_filter
    import lpi_pend_pkg::*;
#(
    parameter int unsigned ID_W       = 16,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned IDB_W      = 5,
    parameter int unsigned MAX_IDBITS = 15,
    parameter int unsigned LPI_FIRST  = 8192
) (
    input  logic              lpi_en,
    input  logic [ADDR_W-1:0] prop_base,
    input  logic [ADDR_W-1:0] pend_base,
    input  logic [IDB_W-1:0]  idbits,
    input  logic [ID_W-1:0]   id,
    output logic              drop,
    output logic [ADDR_W-1:0] pend_addr,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [2:0]        bit_idx
);

    localparam int unsigned LIM_W = (1 << IDB_W) + 2;

    logic [IDB_W-1:0] eff_bits;
    logic [LIM_W-1:0] id_span;
    logic             too_high;
    logic             too_low;

    always_comb begin
        eff_bits = (idbits > IDB_W'(MAX_IDBITS)) ? IDB_W'(MAX_IDBITS) : idbits;
        id_span  = LIM_W'(1) << (LIM_W'(eff_bits) + LIM_W'(1));
        too_high = LIM_W'(id) >= id_span;
        too_low  = id < ID_W'(LPI_FIRST);
        drop     = !lpi_en || (prop_base == '0) || (pend_base == '0) || too_high || too_low;
        pend_addr = pend_base + ADDR_W'(id >> 3);
        cfg_addr  = prop_base + ADDR_W'(id - ID_W'(LPI_FIRST));
        bit_idx   = id[2:0];
    end

endmodule

// File: rtl/lpi_prio_eval.sv
module lpi_prio_eval
    import lpi_pend_pkg::*;
#(
    parameter int unsigned ID_W = 16
) (
    input  logic [7:0]      cfg_byte,
    input  logic            direct,
    input  logic [ID_W-1:0] cand_id,
    input  logic [ID_W-1:0] best_id,
    input  logic [7:0]      best_prio,
    output logic [7:0]      cand_prio,
    output logic            better
);

    logic cand_on;

    always_comb begin
        cand_on   = cfg_byte[0];
        cand_prio = remap_prio(cfg_byte, direct);
        better    = cand_on &&
                    ((cand_prio < best_prio) ||
                     ((cand_prio == best_prio) && (cand_id <= best_id)));
    end

endmodule

// File: rtl/lpi_best_track.sv
module lpi_best_track
    import lpi_pend_pkg::*;
#(
    parameter int unsigned ID_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cand_load,
    input  logic [ID_W-1:0] cand_id,
    input  logic [7:0]      cand_prio,
    input  logic            scan_load,
    input  logic [ID_W-1:0] scan_id,
    input  logic [7:0]      scan_prio,
    output logic [ID_W-1:0] best_id,
    output logic [7:0]      best_prio
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_id   <= '0;
            best_prio <= PRIO_IDLE;
        end else if (scan_load) begin
            best_id   <= scan_id;
            best_prio <= scan_prio;
        end else if (cand_load) begin
            best_id   <= cand_id;
            best_prio <= cand_prio;
        end
    end

    // R6: without a rescan the best priority can only improve or hold
    a_r6_prio_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_load |=> (best_prio <= $past(best_prio)));

    // R7: rescan result and single compare never land together
    a_r7_load_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cand_load && scan_load));

endmodule

// File: rtl/lpi_pend_upd.sv
module lpi_pend_upd
    import lpi_pend_pkg::*;
#(
    parameter int unsigned ID_W       = 16,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned IDB_W      = 5,
    parameter int unsigned MAX_IDBITS = 15,
    parameter int unsigned LPI_FIRST  = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lpi_en,
    input  logic              prio_direct,
    input  logic [ADDR_W-1:0] prop_base,
    input  logic [ADDR_W-1:0] pend_base,
    input  logic [IDB_W-1:0]  idbits,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic              req_level,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic [ID_W-1:0]   best_id,
    output logic [7:0]        best_prio,
    output logic              scan_req,
    input  logic              scan_done,
    input  logic [ID_W-1:0]   scan_id,
    input  logic [7:0]        scan_prio,
    output logic              cpu_update
);

    hdl_state_e state, state_nx;

    logic [ID_W-1:0]   id_q;
    logic              lvl_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [ADDR_W-1:0] caddr_q;
    logic [2:0]        bit_q;
    logic [7:0]        rd_q;
    logic [7:0]        wr_q;
    logic [7:0]        merged;

    logic              f_drop;
    logic [ADDR_W-1:0] f_paddr;
    logic [ADDR_W-1:0] f_caddr;
    logic [2:0]        f_bit;

    logic [7:0]        cand_prio;
    logic              cand_better;
    logic              cand_load;
    logic              scan_load;
    logic              accept;
    logic              byte_same;

    lpi_req_filter #(
        .ID_W(ID_W), .ADDR_W(ADDR_W), .IDB_W(IDB_W),
        .MAX_IDBITS(MAX_IDBITS), .LPI_FIRST(LPI_FIRST)
    ) filt_i (
        .lpi_en    (lpi_en),
        .prop_base (prop_base),
        .pend_base (pend_base),
        .idbits    (idbits),
        .id        (req_id),
        .drop      (f_drop),
        .pend_addr (f_paddr),
        .cfg_addr  (f_caddr),
        .bit_idx   (f_bit)
    );

    lpi_prio_eval #(.ID_W(ID_W)) eval_i (
        .cfg_byte  (mem_rdata),
        .direct    (prio_direct),
        .cand_id   (id_q),
        .best_id   (best_id),
        .best_prio (best_prio),
        .cand_prio (cand_prio),
        .better    (cand_better)
    );

    lpi_best_track #(.ID_W(ID_W)) best_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand_load (cand_load),
        .cand_id   (id_q),
        .cand_prio (cand_prio),
        .scan_load (scan_load),
        .scan_id   (scan_id),
        .scan_prio (scan_prio),
        .best_id   (best_id),
        .best_prio (best_prio)
    );

    always_comb begin
        accept    = req_valid && (state == ST_IDLE);
        byte_same = (mem_rdata[bit_q] == lvl_q);
        merged    = mem_rdata;
        merged[bit_q] = lvl_q;
        cand_load = (state == ST_CFG_RD) && mem_ack && cand_better;
        scan_load = (state == ST_RESCAN) && scan_done;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept && !f_drop) state_nx = ST_PEND_RD;   // accept
            end
            ST_PEND_RD: begin
                if (mem_ack) state_nx = byte_same ? ST_NOTIFY : ST_PEND_WR;  // no-change / modify
            end
            ST_PEND_WR: begin
                if (mem_ack) begin
                    if (lvl_q)                 state_nx = ST_CFG_RD;   // set-done-write
                    else if (id_q == best_id)  state_nx = ST_RESCAN;   // clear-best
                    else                       state_nx = ST_NOTIFY;   // clear-other
                end
            end
            ST_CFG_RD: begin
                if (mem_ack) state_nx = ST_NOTIFY;                  // cfg-done
            end
            ST_RESCAN: begin
                if (scan_done) state_nx = ST_NOTIFY;                // scan-done
            end
            ST_NOTIFY: begin
                state_nx = ST_IDLE;                                 // notify
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = paddr_q;
        mem_wdata  = wr_q;
        scan_req   = 1'b0;
        cpu_update = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = 1'b1;
            ST_PEND_RD: mem_req = 1'b1;
            ST_PEND_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_CFG_RD: begin
                mem_req  = 1'b1;
                mem_addr = caddr_q;
            end
            ST_RESCAN:  scan_req = 1'b1;
            ST_NOTIFY:  cpu_update = 1'b1;
            default:    req_ready = 1'b0;
        endcase
    end

    // Request and byte holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q    <= '0;
            lvl_q   <= 1'b0;
            paddr_q <= '0;
            caddr_q <= '0;
            bit_q   <= '0;
            rd_q    <= '0;
            wr_q    <= '0;
        end else begin
            if (accept && !f_drop) begin
                id_q    <= req_id;
                lvl_q   <= req_level;
                paddr_q <= f_paddr;
                caddr_q <= f_caddr;
                bit_q   <= f_bit;
            end
            if ((state == ST_PEND_RD) && mem_ack) begin
                rd_q <= mem_rdata;
                wr_q <= merged;
            end
        end
    end

    // R1: a dropped request leaves the engine idle with no memory access
    a_r1_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && f_drop) |=> (req_ready && !mem_req));

    // R3: an unchanged bit never leads to a write
    a_r3_skip_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PEND_RD) && mem_ack && byte_same) |=> !mem_req);

    // R4: write-back differs from the read byte in exactly the target bit
    a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (($countones(mem_wdata ^ rd_q) == 1) && (mem_wdata[bit_q] == lvl_q)));

    // R7: rescan only on a clear, held until done
    a_r7_scan_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |-> !lvl_q);
    a_r7_scan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_req && !scan_done) |=> scan_req);

    // R8: single-cycle notify followed by ready
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_update |=> (!cpu_update && req_ready));

    // R9: memory request is held stable until acknowledged
    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

endmodule

// File: tb/lpi_pend_upd_tb_top.sv
module lpi_pend_upd_tb_top;

    localparam int ID_W   = 16;
    localparam int ADDR_W = 32;
    localparam int IDB_W  = 5;
    localparam logic [31:0] PEND_B = 32'h0000_1000;
    localparam logic [31:0] PROP_B = 32'h0000_2000;

    typedef struct packed {
        logic [15:0] id;
        logic        lvl;
        logic        wr;
        logic        scan;
        logic [15:0] bid;
        logic [7:0]  bprio;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{16'd8200, 1'b1, 1'b1, 1'b0, 16'd8200, 8'hD0},  // first set, enabled
        '{16'd8200, 1'b1, 1'b0, 1'b0, 16'd8200, 8'hD0},  // repeat set, no write
        '{16'd8210, 1'b1, 1'b1, 1'b0, 16'd8210, 8'hA0},  // strictly lower prio
        '{16'd8230, 1'b1, 1'b1, 1'b0, 16'd8210, 8'hA0},  // equal prio, higher id
        '{16'd8220, 1'b1, 1'b1, 1'b0, 16'd8210, 8'hA0},  // disabled entry
        '{16'd8205, 1'b1, 1'b1, 1'b0, 16'd8205, 8'hA0},  // equal prio, lower id
        '{16'd8230, 1'b0, 1'b1, 1'b0, 16'd8205, 8'hA0},  // clear non-best
        '{16'd8230, 1'b0, 1'b0, 1'b0, 16'd8205, 8'hA0},  // repeat clear
        '{16'd8205, 1'b0, 1'b1, 1'b1, 16'd8210, 8'hA0},  // clear best: rescan
        '{16'd8210, 1'b1, 1'b0, 1'b0, 16'd8210, 8'hA0}   // already pending
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lpi_en = 1'b1;
    logic prio_direct = 1'b0;
    logic [ADDR_W-1:0] prop_base = PROP_B;
    logic [ADDR_W-1:0] pend_base = PEND_B;
    logic [IDB_W-1:0]  idbits = 5'd15;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ID_W-1:0] req_id = '0;
    logic req_level = 1'b0;
    logic mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [7:0] mem_rdata = '0;
    logic [ID_W-1:0] best_id;
    logic [7:0] best_prio;
    logic scan_req;
    logic scan_done = 1'b0;
    logic [ID_W-1:0] scan_id = 16'd8210;
    logic [7:0] scan_prio = 8'hA0;
    logic cpu_update;

    always #2.5 clk = ~clk;

    lpi_pend_upd dut_i (
        .clk(clk), .rst_n(rst_n), .lpi_en(lpi_en), .prio_direct(prio_direct),
        .prop_base(prop_base), .pend_base(pend_base), .idbits(idbits),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_level(req_level),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .best_id(best_id), .best_prio(best_prio),
        .scan_req(scan_req), .scan_done(scan_done), .scan_id(scan_id), .scan_prio(scan_prio),
        .cpu_update(cpu_update)
    );

    // Memory model with variable latency
    logic [7:0] mem [0:4095];
    int lat = 1;
    int mcnt = 0;
    int rd_cnt = 0, wr_cnt = 0, upd_cnt = 0, scan_cnt = 0, scnt = 0;
    logic [31:0] last_rd_addr = '0, last_wr_addr = '0;
    logic [7:0]  last_wr_data = '0;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (mcnt >= lat - 1) begin
                mcnt    <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[11:0]] <= mem_wdata;
                    wr_cnt       <= wr_cnt + 1;
                    last_wr_addr <= mem_addr;
                    last_wr_data <= mem_wdata;
                end else begin
                    mem_rdata    <= mem[mem_addr[11:0]];
                    rd_cnt       <= rd_cnt + 1;
                    last_rd_addr <= mem_addr;
                end
            end else begin
                mcnt <= mcnt + 1;
            end
        end
    end

    // Scanner model and notify counter
    always @(posedge clk) begin
        scan_done <= 1'b0;
        if (cpu_update) upd_cnt <= upd_cnt + 1;
        if (scan_req && !scan_done) begin
            if (scnt == 2) begin
                scnt      <= 0;
                scan_done <= 1'b1;
                scan_cnt  <= scan_cnt + 1;
            end else begin
                scnt <= scnt + 1;
            end
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [15:0] id, input logic lvl, input bit expect_drop);
        @(negedge clk);
        req_valid = 1'b1;
        req_id    = id;
        req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
        if (expect_drop) chk("R1 ready stays high on drop", 32'(req_ready), 32'd1);
        else             chk("R9 ready low while busy", 32'(req_ready), 32'd0);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
        mem[12'h008] = 8'hA1;   // 8200
        mem[12'h012] = 8'h41;   // 8210
        mem[12'h01C] = 8'h40;   // 8220 disabled
        mem[12'h026] = 8'h41;   // 8230
        mem[12'h00D] = 8'h41;   // 8205
        mem[12'h030] = 8'h31;   // 8240
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 ready", 32'(req_ready), 32'd1);
        chk("R10 mem_req", 32'(mem_req), 32'd0);
        chk("R10 scan_req", 32'(scan_req), 32'd0);
        chk("R10 cpu_update", 32'(cpu_update), 32'd0);
        chk("R10 best_prio", 32'(best_prio), 32'hFF);
        chk("R10 best_id", 32'(best_id), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            int w0, s0, u0, r0;
            logic [7:0] old_b;
            logic [31:0] paddr;
            paddr = PEND_B + 32'(VEC[i].id >> 3);
            old_b = mem[paddr[11:0]];
            w0 = wr_cnt; s0 = scan_cnt; u0 = upd_cnt; r0 = rd_cnt;
            lat = (i % 3) + 1;
            do_req(VEC[i].id, VEC[i].lvl, 1'b0);
            chk("R3 write count", 32'(wr_cnt - w0), 32'(VEC[i].wr));
            if (VEC[i].wr) begin
                chk("R2 write address", last_wr_addr, paddr);
                chk("R4 write data", 32'(last_wr_data),
                    32'(old_b ^ (8'd1 << VEC[i].id[2:0])));
            end
            if (VEC[i].wr && VEC[i].lvl) begin
                chk("R5 config read address", last_rd_addr, PROP_B + 32'(VEC[i].id) - 32'd8192);
                chk("R6 no rescan on set", 32'(scan_cnt - s0), 32'd0);
            end
            if (!VEC[i].wr) chk("R3 only one read", 32'(rd_cnt - r0), 32'd1);
            chk("R7 rescan count", 32'(scan_cnt - s0), 32'(VEC[i].scan));
            chk("R6 best id", 32'(best_id), 32'(VEC[i].bid));
            chk("R6 best prio", 32'(best_prio), 32'(VEC[i].bprio));
            chk("R8 one notify", 32'(upd_cnt - u0), 32'd1);
        end

        // R5 direct priority mode
        prio_direct = 1'b1;
        lat = 2;
        do_req(16'd8240, 1'b1, 1'b0);
        chk("R5 direct prio", 32'(best_prio), 32'h30);
        chk("R5 direct id", 32'(best_id), 32'd8240);
        chk("R5 cfg addr", last_rd_addr, PROP_B + 32'd48);

        // R1 drop conditions, each alone
        begin
            int r0, u0;
            r0 = rd_cnt; u0 = upd_cnt;
            lpi_en = 1'b0;
            do_req(16'd8210, 1'b0, 1'b1);
            lpi_en = 1'b1;
            prop_base = '0;
            do_req(16'd8210, 1'b0, 1'b1);
            prop_base = PROP_B;
            pend_base = '0;
            do_req(16'd8210, 1'b0, 1'b1);
            pend_base = PEND_B;
            do_req(16'd8191, 1'b1, 1'b1);
            idbits = 5'd13;
            do_req(16'd16384, 1'b1, 1'b1);
            chk("R1 no memory access on drop", 32'(rd_cnt - r0), 32'd0);
            chk("R1 no notify on drop", 32'(upd_cnt - u0), 32'd0);
            chk("R1 best untouched", 32'(best_id), 32'd8240);
        end

        // R1 boundary ID accepted
        begin
            int w0;
            w0 = wr_cnt;
            do_req(16'd16383, 1'b1, 1'b0);
            chk("R1 top ID accepted", 32'(wr_cnt - w0), 32'd1);
            chk("R2 top ID address", last_wr_addr, PEND_B + 32'd2047);
            chk("R5 disabled top ID ignored", 32'(best_id), 32'd8240);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule